// File: doc/BRIEF.md
# I2C Slave Address Status Flags

This block sits behind the bus-condition detector of a multi-master I2C interface and keeps three status flags for the slave side. The flags are the last received bit, general call seen and own address matched. The detector hands the block START and STOP strobes, one strobe per SCL rising edge together with the SDA level it sampled, and a marker that tells the ninth (acknowledge) clock of a byte apart from the data clocks. The CPU side supplies a strobe for each write to the data shift register, plus the configuration fields.

The block examines the first byte after a START or repeated START. It compares that byte against the programmed slave address, using either the 7-bit rule or the 10-bit first-byte rule, and sets the flags on the clock edge that samples the eighth bit. Bus conditions clear the general-call flag. A CPU write to the data shift register clears the address-match and last-bit flags. The block also decodes a two-bit selector into enables for two physical SCL/SDA pin pairs.

Top module: `i2c_slave_status`

## Requirements
- R1: A synchronous active-high reset clears lastBit, genCall and addrMatch to 0.
- R2: bitCount code 0 selects 8-bit frames, and codes 1 to 7 select frames of 8 minus the code bits (code 7 is 1 bit). Address comparison happens only when the frame is 8 bits. With any other code, no flag is set by the first frame.
- R3: With tenBitMode = 0, addrMatch is set at the edge that samples the eighth bit after START when bits 7:1 of that byte (MSB first on the wire) equal slaveAddr[7:1]. The R/W bit (bit 0) is ignored.
- R4: With tenBitMode = 1, addrMatch is set only when all 8 bits of the first byte, including R/W, equal slaveAddr.
- R5: A first byte of 0x00 sets genCall in both address modes. In 7-bit mode it also sets addrMatch.
- R6: startDet or stopDet clears genCall on the next clock edge.
- R7: dsrWrite clears addrMatch and lastBit. If a data bit or a match is sampled in the same cycle, the bus event wins.
- R8: On every data clock (sclRise with ackClk = 0), lastBit takes the sampled SDA level. On the acknowledge clock (ackClk = 1), lastBit takes the SDA level only when ackMode = 1: 0 for ACK given, 1 for no ACK. Otherwise the acknowledge clock leaves lastBit unchanged.
- R9: With freeData = 1 or ifEnable = 0, no address comparison takes place, and neither genCall nor addrMatch is set.
- R10: Only the first byte after a START is compared. Later bytes of the same transfer never set addrMatch or genCall.
- R11: pairEn[0] follows portSel[0] and pairEn[1] follows portSel[1]. So 01 selects pair 1, 10 selects pair 2, 11 selects both and 00 selects none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ifEnable | input | 1 | Interface enable |
| tenBitMode | input | 1 | 1 = 10-bit addressing, 0 = 7-bit |
| freeData | input | 1 | 1 = free data format, no address compare |
| ackMode | input | 1 | 1 = acknowledge clock updates lastBit |
| bitCount | input | 3 | Bits-per-frame code |
| slaveAddr | input | 8 | Programmed slave address register |
| portSel | input | 2 | Pin pair connection select |
| startDet | input | 1 | START / repeated START detected strobe |
| stopDet | input | 1 | STOP detected strobe |
| sclRise | input | 1 | SCL rising edge strobe, SDA sampled |
| ackClk | input | 1 | Marks the current sclRise as the acknowledge clock |
| sdaBit | input | 1 | SDA level sampled at sclRise |
| dsrWrite | input | 1 | CPU write to the data shift register |
| lastBit | output | 1 | Last received bit / acknowledge flag |
| genCall | output | 1 | General call detected |
| addrMatch | output | 1 | Slave address matched |
| pairEn | output | 2 | Enable per physical SCL/SDA pin pair |

## Verification
The table sends first bytes that equal the address and differ only in R/W, plus one that differs in an address bit. This tells the 7-bit rule, which ignores bit 0, apart from the 10-bit rule, which compares it. An all-zero byte in both modes separates a general call from an ordinary match. Directed patterns send a matching byte under a short frame code, in free data format, with the interface disabled and as a second byte. These show that the comparison is gated and is not a plain equality test. Acknowledge levels under both ackMode settings, and a CPU write in the same cycle as the eighth bit, show how lastBit is sourced and which event takes priority.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  typedef struct packed {
    logic shiftBit;   // data clock: shift and record SDA
    logic ackSample;  // acknowledge clock in ack mode
    logic addrCheck;  // eighth bit of first byte after START, compare now
    logic cpuClear;   // CPU wrote the data shift register
    logic busClear;   // START or STOP seen
  } strobe_t;
endpackage

// File: rtl/i2cs_ctrl.sv
module i2cs_ctrl #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ifEnable,
  input  logic                freeData,
  input  logic                ackMode,
  input  logic [CNT_W-1:0]    bitCount,
  input  logic                startDet,
  input  logic                stopDet,
  input  logic                sclRise,
  input  logic                ackClk,
  input  logic                dsrWrite,
  output i2cs_pkg::strobe_t   stb
);
  localparam int IDX_W = $clog2(ADDR_W + 1);
  localparam logic [IDX_W-1:0] FULL = IDX_W'(ADDR_W);

  function automatic logic [IDX_W-1:0] frameBits(input logic [CNT_W-1:0] code);
    if (code == '0) return FULL;
    else            return FULL - IDX_W'(code);
  endfunction

  logic             inAddr;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;
  logic             dataEdge;
  logic             busEvt;

  assign lastIdx  = frameBits(bitCount) - IDX_W'(1);
  assign dataEdge = sclRise & ~ackClk;
  assign busEvt   = startDet | stopDet;

  always_ff @(posedge clk) begin
    if (rst) begin
      inAddr <= 1'b0;
      bitIdx <= '0;
    end else if (!ifEnable || stopDet) begin
      inAddr <= 1'b0;
      bitIdx <= '0;
    end else if (startDet) begin
      inAddr <= 1'b1;
      bitIdx <= '0;
    end else if (dataEdge && inAddr) begin
      if (bitIdx == lastIdx) begin
        inAddr <= 1'b0;
        bitIdx <= '0;
      end else begin
        bitIdx <= bitIdx + IDX_W'(1);
      end
    end
  end

  always_comb begin
    stb.shiftBit  = dataEdge;
    stb.ackSample = sclRise & ackClk & ackMode;
    stb.cpuClear  = dsrWrite;
    stb.busClear  = busEvt;
    stb.addrCheck = dataEdge & inAddr & ifEnable & ~freeData & ~busEvt &
                    (bitIdx == FULL - IDX_W'(1)) & (frameBits(bitCount) == FULL);
  end
endmodule

// File: rtl/i2cs_dpath.sv
module i2cs_dpath #(
  parameter int ADDR_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               tenBitMode,
  input  logic [ADDR_W-1:0]  slaveAddr,
  input  logic               sdaBit,
  input  i2cs_pkg::strobe_t  stb,
  output logic               lastBit,
  output logic               genCall,
  output logic               addrMatch
);
  logic [ADDR_W-1:0] shiftReg;
  logic [ADDR_W-1:0] nextByte;
  logic              isZero;
  logic              hit7;
  logic              hit10;
  logic              matchNow;

  assign nextByte = {shiftReg[ADDR_W-2:0], sdaBit};
  assign isZero   = (nextByte == '0);
  assign hit7     = (nextByte[ADDR_W-1:1] == slaveAddr[ADDR_W-1:1]);
  assign hit10    = (nextByte == slaveAddr);
  assign matchNow = tenBitMode ? hit10 : (hit7 | isZero);

  always_ff @(posedge clk) begin
    if (rst) shiftReg <= '0;
    else if (stb.shiftBit) shiftReg <= nextByte;
  end

  // last bit: bus sample wins over CPU clear
  always_ff @(posedge clk) begin
    if (rst) lastBit <= 1'b0;
    else if (stb.shiftBit || stb.ackSample) lastBit <= sdaBit;
    else if (stb.cpuClear) lastBit <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) genCall <= 1'b0;
    else if (stb.busClear) genCall <= 1'b0;
    else if (stb.addrCheck && isZero) genCall <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) addrMatch <= 1'b0;
    else if (stb.addrCheck && matchNow) addrMatch <= 1'b1;
    else if (stb.cpuClear) addrMatch <= 1'b0;
  end
endmodule

// File: rtl/i2c_slave_status.sv
module i2c_slave_status #(
  parameter int ADDR_W    = 8,
  parameter int CNT_W     = 3,
  parameter int NUM_PAIRS = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ifEnable,
  input  logic                 tenBitMode,
  input  logic                 freeData,
  input  logic                 ackMode,
  input  logic [CNT_W-1:0]     bitCount,
  input  logic [ADDR_W-1:0]    slaveAddr,
  input  logic [NUM_PAIRS-1:0] portSel,
  input  logic                 startDet,
  input  logic                 stopDet,
  input  logic                 sclRise,
  input  logic                 ackClk,
  input  logic                 sdaBit,
  input  logic                 dsrWrite,
  output logic                 lastBit,
  output logic                 genCall,
  output logic                 addrMatch,
  output logic [NUM_PAIRS-1:0] pairEn
);
  i2cs_pkg::strobe_t stb;

  i2cs_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) ctrl (
    .clk(clk), .rst(rst), .ifEnable(ifEnable), .freeData(freeData),
    .ackMode(ackMode), .bitCount(bitCount), .startDet(startDet),
    .stopDet(stopDet), .sclRise(sclRise), .ackClk(ackClk),
    .dsrWrite(dsrWrite), .stb(stb)
  );

  i2cs_dpath #(.ADDR_W(ADDR_W)) dpath (
    .clk(clk), .rst(rst), .tenBitMode(tenBitMode), .slaveAddr(slaveAddr),
    .sdaBit(sdaBit), .stb(stb), .lastBit(lastBit), .genCall(genCall),
    .addrMatch(addrMatch)
  );

  // R11: one enable per pin pair
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_pair
    assign pairEn[g] = portSel[g];
  end
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             ifEnable,
  input logic             freeData,
  input logic             ackMode,
  input logic [CNT_W-1:0] bitCount,
  input logic             startDet,
  input logic             stopDet,
  input logic             sclRise,
  input logic             ackClk,
  input logic             dsrWrite,
  input logic             lastBit,
  input logic             genCall,
  input logic             addrMatch
);
  p_reset_flags_r1: assert property (@(posedge clk)
    rst |=> (!lastBit && !genCall && !addrMatch));

  p_match_source_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(addrMatch) |-> $past(sclRise && !ackClk && ifEnable && !freeData && bitCount == '0));

  p_gc_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(genCall) |-> $past(sclRise && !ackClk && ifEnable && !freeData));

  p_bus_clear_gc_r6: assert property (@(posedge clk) disable iff (rst)
    (startDet || stopDet) |=> !genCall);

  p_cpu_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (dsrWrite && !sclRise) |=> (!addrMatch && !lastBit));

  p_ack_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (sclRise && ackClk && !ackMode && !dsrWrite) |=> $stable(lastBit));
endmodule

bind i2c_slave_status i2cs_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .ifEnable(ifEnable), .freeData(freeData),
  .ackMode(ackMode), .bitCount(bitCount), .startDet(startDet),
  .stopDet(stopDet), .sclRise(sclRise), .ackClk(ackClk),
  .dsrWrite(dsrWrite), .lastBit(lastBit), .genCall(genCall),
  .addrMatch(addrMatch)
);

// File: tb/i2c_slave_status_test.sv
`timescale 1ns/1ps
module i2c_slave_status_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst = 1'b1, ifEnable = 1'b1, tenBitMode = 1'b0, freeData = 1'b0, ackMode = 1'b0;
  logic [2:0] bitCount = 3'd0;
  logic [7:0] slaveAddr = 8'hA4;
  logic [1:0] portSel = 2'b00;
  logic startDet = 0, stopDet = 0, sclRise = 0, ackClk = 0, sdaBit = 0, dsrWrite = 0;
  logic lastBit, genCall, addrMatch;
  logic [1:0] pairEn;

  int checks = 0, fails = 0;
  bit finished = 0;

  i2c_slave_status uut (
    .clk(clk), .rst(rst), .ifEnable(ifEnable), .tenBitMode(tenBitMode),
    .freeData(freeData), .ackMode(ackMode), .bitCount(bitCount),
    .slaveAddr(slaveAddr), .portSel(portSel), .startDet(startDet),
    .stopDet(stopDet), .sclRise(sclRise), .ackClk(ackClk), .sdaBit(sdaBit),
    .dsrWrite(dsrWrite), .lastBit(lastBit), .genCall(genCall),
    .addrMatch(addrMatch), .pairEn(pairEn)
  );

  // {tenBit, slaveAddr, firstByte, expMatch, expGc}
  localparam logic [18:0] VEC [8] = '{
    {1'b0, 8'hA4, 8'hA4, 1'b1, 1'b0},
    {1'b0, 8'hA4, 8'hA5, 1'b1, 1'b0},
    {1'b0, 8'hA4, 8'hA6, 1'b0, 1'b0},
    {1'b0, 8'hA4, 8'h00, 1'b1, 1'b1},
    {1'b1, 8'hF2, 8'hF2, 1'b1, 1'b0},
    {1'b1, 8'hF2, 8'hF3, 1'b0, 1'b0},
    {1'b1, 8'hF2, 8'h00, 1'b0, 1'b1},
    {1'b0, 8'h24, 8'h25, 1'b1, 1'b0}
  };

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic pulseStart(); startDet = 1; @(negedge clk); startDet = 0; @(negedge clk); endtask
  task automatic pulseStop();  stopDet = 1;  @(negedge clk); stopDet = 0;  @(negedge clk); endtask
  task automatic pulseWrite(); dsrWrite = 1; @(negedge clk); dsrWrite = 0; @(negedge clk); endtask

  task automatic sendByte(input logic [7:0] b, input logic ackLvl, input logic wrLast);
    for (int i = 7; i >= 0; i--) begin
      sdaBit = b[i]; sclRise = 1; dsrWrite = wrLast && (i == 0);
      @(negedge clk);
      sclRise = 0; dsrWrite = 0;
      @(negedge clk);
    end
    ackClk = 1; sclRise = 1; sdaBit = ackLvl;
    @(negedge clk);
    ackClk = 0; sclRise = 0;
    @(negedge clk);
  endtask

  task automatic freshFrame();
    pulseWrite(); pulseStop(); pulseStart();
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(lastBit, 1'b0, "R1 lastBit");
    chk(genCall, 1'b0, "R1 genCall");
    chk(addrMatch, 1'b0, "R1 addrMatch");

    // table: R3 R4 R5
    foreach (VEC[k]) begin
      tenBitMode = VEC[k][18];
      slaveAddr  = VEC[k][17:10];
      freshFrame();
      sendByte(VEC[k][9:2], 1'b1, 1'b0);
      chk(addrMatch, VEC[k][1], $sformatf("R3/R4 match vec %0d", k));
      chk(genCall, VEC[k][0], $sformatf("R5 genCall vec %0d", k));
      chk(lastBit, VEC[k][2], $sformatf("R8 lastBit vec %0d", k));
    end

    // R6 general call cleared by START and by STOP
    tenBitMode = 0; slaveAddr = 8'hA4;
    freshFrame(); sendByte(8'h00, 1'b0, 1'b0);
    chk(genCall, 1'b1, "R6 gc set before start");
    pulseStart();
    chk(genCall, 1'b0, "R6 gc cleared by START");
    sendByte(8'h00, 1'b0, 1'b0);
    pulseStop();
    chk(genCall, 1'b0, "R6 gc cleared by STOP");

    // R7 CPU write clears; same-cycle bus event wins
    freshFrame(); sendByte(8'hA5, 1'b1, 1'b0);
    chk(addrMatch, 1'b1, "R7 match before write");
    pulseWrite();
    chk(addrMatch, 1'b0, "R7 match cleared by write");
    chk(lastBit, 1'b0, "R7 lastBit cleared by write");
    freshFrame(); sendByte(8'hA5, 1'b1, 1'b1);
    chk(addrMatch, 1'b1, "R7 match wins over same-cycle write");
    chk(lastBit, 1'b1, "R7 sample wins over same-cycle write");

    // R10 second byte not compared
    freshFrame(); sendByte(8'hA4, 1'b0, 1'b0);
    pulseWrite();
    sendByte(8'hA4, 1'b0, 1'b0);
    chk(addrMatch, 1'b0, "R10 second byte ignored");
    sendByte(8'h00, 1'b0, 1'b0);
    chk(genCall, 1'b0, "R10 second zero byte no gc");

    // R2 short frame code blocks comparison
    bitCount = 3'd1;
    freshFrame(); sendByte(8'hA4, 1'b0, 1'b0);
    chk(addrMatch, 1'b0, "R2 code 1 no match");
    bitCount = 3'd7;
    freshFrame(); sendByte(8'h00, 1'b0, 1'b0);
    chk(genCall, 1'b0, "R2 code 7 no gc");
    bitCount = 3'd0;

    // R9 free data and disabled
    freeData = 1;
    freshFrame(); sendByte(8'h00, 1'b0, 1'b0);
    chk(addrMatch, 1'b0, "R9 free data no match");
    chk(genCall, 1'b0, "R9 free data no gc");
    freeData = 0; ifEnable = 0;
    freshFrame(); sendByte(8'hA4, 1'b0, 1'b0);
    chk(addrMatch, 1'b0, "R9 disabled no match");
    ifEnable = 1;

    // R8 acknowledge clock handling
    ackMode = 1;
    freshFrame(); sendByte(8'hA5, 1'b0, 1'b0);
    chk(lastBit, 1'b0, "R8 ack given");
    freshFrame(); sendByte(8'hA4, 1'b1, 1'b0);
    chk(lastBit, 1'b1, "R8 no ack");
    ackMode = 0;
    freshFrame(); sendByte(8'hA5, 1'b0, 1'b0);
    chk(lastBit, 1'b1, "R8 ack ignored outside ack mode");

    // R11 pin pair select
    for (int s = 0; s < 4; s++) begin
      portSel = 2'(s);
      @(negedge clk);
      chk(pairEn[0], s[0], $sformatf("R11 pair1 sel %0d", s));
      chk(pairEn[1], s[1], $sformatf("R11 pair2 sel %0d", s));
    end

    // R1 reset mid-operation
    freshFrame(); sendByte(8'h00, 1'b1, 1'b0);
    rst = 1; @(negedge clk); rst = 0;
    chk(addrMatch, 1'b0, "R1 match after reset");
    chk(genCall, 1'b0, "R1 gc after reset");
    chk(lastBit, 1'b0, "R1 lastBit after reset");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule